// File: doc/BRIEF.md
# Six-Step Commutation Output Controller

This block drives a set of complementary PWM output pairs for six-step drive of a brushless motor. Each channel has a true output and a complementary output. Both are built from a reference signal that the external counter supplies. A per-channel output-mode field can override that reference: it can force the reference low, force it high, or pass the counter's waveform through. Separate enables gate the true output and the complementary output.

The mode and the two enables are double-buffered. Software writes the configuration for the next step into a preload copy. A commutation event moves every channel's preload copy into its active copy on the same clock edge, so all pins change configuration together. A commutation event comes from a software strobe or from a rising edge on a hardware trigger input. Every event sets a status flag. The flag can drive an interrupt, and each event can issue a one-cycle DMA request.

Two small state machines control the sequencing. The trigger tracker has the states TRG_LOW and TRG_HIGH. It moves from TRG_LOW to TRG_HIGH when the trigger reads 1, and from TRG_HIGH to TRG_LOW when the trigger reads 0. An edge event is raised only while the tracker is in TRG_LOW and the trigger reads 1. Reset places the tracker in TRG_HIGH. The flag keeper has the states FLAG_IDLE and FLAG_SET. It moves from FLAG_IDLE to FLAG_SET on any event. It moves from FLAG_SET to FLAG_IDLE on a clear request that arrives in a cycle with no event. In every other case it holds its state.

Top module: `sixstep_commutator`

## Requirements
- R1: While reset is asserted, every true and complementary output is 0, and the status flag, the interrupt and the DMA request are 0.
- R2: A write to a channel's preload register (address 3 + channel; data bits [3:0] = mode, bit 4 = true-output enable, bit 5 = complementary-output enable) has no effect on any output until a commutation event occurs.
- R3: Writing address 0 with data bit 0 = 1 is a commutation event. On the clock edge that ends that cycle, every channel's active configuration takes its preload value.
- R4: A cycle in which the trigger reads 1 and read 0 in the previous cycle is a commutation event. A trigger held at 1 produces no further events. Out of reset, the trigger's previous value is taken to be 1.
- R5: Mode code 4'b0100 forces the reference to 0, whatever the counter reference does.
- R6: Mode code 4'b0101 forces the reference to 1. Any other mode code passes the channel's counter reference through unchanged.
- R7: An output whose enable is 0 drives 0. With its enable set, the true output equals the reference and the complementary output equals the inverted reference.
- R8: Each event sets the status flag. Writing address 1 with data bit 0 = 0 clears the flag. Writing bit 0 = 1 has no effect. An event in the same cycle as a clear leaves the flag set.
- R9: The interrupt output equals the status flag ANDed with the interrupt enable (address 2, data bit 0).
- R10: With the DMA enable set (address 2, data bit 1), the DMA request is high for the single cycle after each event cycle. A software strobe and a trigger edge in the same cycle count as one event.
- R11: A preload write in the same cycle as a trigger event does not reach the active configuration at that event. The active copy takes the value held before the write, and the new value waits for the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_ref | input | NCH | Counter-derived reference, one bit per channel |
| trg_in | input | 1 | Hardware commutation trigger |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 6 | Register write data |
| oc | output | NCH | True outputs |
| ocn | output | NCH | Complementary outputs |
| status_flag | output | 1 | Commutation status flag |
| irq | output | 1 | Commutation interrupt |
| dma_req | output | 1 | Commutation DMA request, one cycle per event |

## Verification
The assertions assume that the trigger and the write port are synchronous to `clk` and change only between edges. They also assume that a write addressed to a channel outside the configured count is harmless. The stimulus drives every input one nanosecond after a rising edge. It addresses only the defined registers. It releases reset while the trigger is low, so the first cycle after reset never has to decide whether an edge occurred.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;

    localparam int MODE_W = 4;
    localparam int CFG_W  = MODE_W + 2;

    localparam logic [MODE_W-1:0] MODE_FORCE_LOW  = 4'b0100;
    localparam logic [MODE_W-1:0] MODE_FORCE_HIGH = 4'b0101;

    localparam int ADDR_GEN    = 0;
    localparam int ADDR_STATUS = 1;
    localparam int ADDR_CTRL   = 2;
    localparam int ADDR_CHBASE = 3;

    typedef struct packed {
        logic              comp_en;
        logic              main_en;
        logic [MODE_W-1:0] mode;
    } cfg_t;

    typedef enum logic { TRG_LOW, TRG_HIGH } trg_state_e;
    typedef enum logic { FLAG_IDLE, FLAG_SET } flag_state_e;

endpackage

// File: rtl/sixstep_trig_edge.sv
module sixstep_trig_edge
    import sixstep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trg_in,
    output logic trig_evt
);

    trg_state_e st_q, st_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TRG_HIGH;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx    = st_q;
        trig_evt = 1'b0;
        unique case (st_q)
            TRG_LOW: begin
                if (trg_in) begin
                    st_nx    = TRG_HIGH;
                    trig_evt = 1'b1;
                end
            end
            TRG_HIGH: begin
                if (!trg_in) st_nx = TRG_LOW;
            end
        endcase
    end

endmodule

// File: rtl/sixstep_event_ctrl.sv
module sixstep_event_ctrl
    import sixstep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr_req,
    input  logic irq_en,
    input  logic dma_en,
    output logic status_flag,
    output logic irq,
    output logic dma_req
);

    flag_state_e st_q, st_nx;
    logic        dma_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FLAG_IDLE;
            dma_q <= 1'b0;
        end else begin
            st_q  <= st_nx;
            dma_q <= evt && dma_en;
        end
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            FLAG_IDLE: if (evt) st_nx = FLAG_SET;
            FLAG_SET:  if (!evt && clr_req) st_nx = FLAG_IDLE;
        endcase
    end

    always_comb begin
        status_flag = (st_q == FLAG_SET);
        irq         = status_flag && irq_en;
        dma_req     = dma_q;
    end

endmodule

// File: rtl/sixstep_chan.sv
module sixstep_chan
    import sixstep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pl_we,
    input  cfg_t pl_data,
    input  logic commute,
    input  logic pwm_ref,
    output cfg_t active,
    output logic oc,
    output logic ocn
);

    cfg_t pl_q, act_q;
    logic ref_eff;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pl_q  <= '0;
            act_q <= '0;
        end else begin
            if (commute) act_q <= pl_q;
            if (pl_we)   pl_q  <= pl_data;
        end
    end

    always_comb begin
        unique case (act_q.mode)
            MODE_FORCE_LOW:  ref_eff = 1'b0;
            MODE_FORCE_HIGH: ref_eff = 1'b1;
            default:         ref_eff = pwm_ref;
        endcase
        oc     = act_q.main_en && ref_eff;
        ocn    = act_q.comp_en && !ref_eff;
        active = act_q;
    end

endmodule

// File: rtl/sixstep_commutator.sv
module sixstep_commutator
    import sixstep_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    pwm_ref,
    input  logic              trg_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CFG_W-1:0]  wr_data,
    output logic [NCH-1:0]    oc,
    output logic [NCH-1:0]    ocn,
    output logic              status_flag,
    output logic              irq,
    output logic              dma_req
);

    localparam int SH_W = NCH * CFG_W;

    logic            trig_evt, sw_evt, evt, clr_req;
    logic [1:0]      ctrl_q;
    logic [SH_W-1:0] sh_flat;

    always_comb begin
        sw_evt  = wr_en && (wr_addr == ADDR_W'(ADDR_GEN)) && wr_data[0];
        clr_req = wr_en && (wr_addr == ADDR_W'(ADDR_STATUS)) && !wr_data[0];
        evt     = sw_evt || trig_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= 2'b00;
        else if (wr_en && (wr_addr == ADDR_W'(ADDR_CTRL)))
            ctrl_q <= wr_data[1:0];
    end

    sixstep_trig_edge u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .trg_in   (trg_in),
        .trig_evt (trig_evt)
    );

    sixstep_event_ctrl u_evt (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt),
        .clr_req     (clr_req),
        .irq_en      (ctrl_q[0]),
        .dma_en      (ctrl_q[1]),
        .status_flag (status_flag),
        .irq         (irq),
        .dma_req     (dma_req)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        cfg_t act;
        sixstep_chan u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .pl_we   (wr_en && (wr_addr == ADDR_W'(ADDR_CHBASE + g))),
            .pl_data (cfg_t'(wr_data)),
            .commute (evt),
            .pwm_ref (pwm_ref[g]),
            .active  (act),
            .oc      (oc[g]),
            .ocn     (ocn[g])
        );
        assign sh_flat[g*CFG_W +: CFG_W] = act;
    end

endmodule

// File: rtl/sixstep_commutator_chk.sv
module sixstep_commutator_chk
    import sixstep_pkg::*;
#(
    parameter int NCH = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 evt,
    input logic                 trig_evt,
    input logic                 trg_in,
    input logic                 clr_req,
    input logic                 status_flag,
    input logic                 irq,
    input logic                 dma_req,
    input logic [NCH*CFG_W-1:0] sh_flat,
    input logic [NCH-1:0]       oc,
    input logic [NCH-1:0]       ocn
);

    // R2 / R3: active configuration moves only on an event
    a_r3_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(sh_flat));

    a_r4_trig_edge: assert property (@(posedge clk) disable iff (!rst_n)
        trig_evt |-> (trg_in && !$past(trg_in)));

    a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> status_flag);

    a_r8_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (status_flag && !clr_req) |=> status_flag);

    a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> status_flag);

    a_r10_dma_after_evt: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> $past(evt));

    for (genvar g = 0; g < NCH; g++) begin : g_pin
        cfg_t c;
        assign c = cfg_t'(sh_flat[g*CFG_W +: CFG_W]);

        a_r7_main_off: assert property (@(posedge clk) disable iff (!rst_n)
            !c.main_en |-> !oc[g]);

        a_r7_comp_off: assert property (@(posedge clk) disable iff (!rst_n)
            !c.comp_en |-> !ocn[g]);

        a_r7_pair_opposite: assert property (@(posedge clk) disable iff (!rst_n)
            (c.main_en && c.comp_en) |-> (oc[g] != ocn[g]));

        a_r5_force_low: assert property (@(posedge clk) disable iff (!rst_n)
            (c.mode == MODE_FORCE_LOW) |-> !oc[g]);
    end

endmodule

bind sixstep_commutator sixstep_commutator_chk #(.NCH(NCH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt         (evt),
    .trig_evt    (trig_evt),
    .trg_in      (trg_in),
    .clr_req     (clr_req),
    .status_flag (status_flag),
    .irq         (irq),
    .dma_req     (dma_req),
    .sh_flat     (sh_flat),
    .oc          (oc),
    .ocn         (ocn)
);

// File: tb/sim_sixstep_commutator.sv
`timescale 1ns/1ps
module sim_sixstep_commutator;

    localparam int NCH = 3;
    localparam int AW  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] pwm_ref = '0;
    logic           trg_in = 1'b0;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [5:0]     wr_data = '0;
    logic [NCH-1:0] oc, ocn;
    logic           status_flag, irq, dma_req;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sixstep_commutator #(.NCH(NCH), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .pwm_ref(pwm_ref), .trg_in(trg_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .oc(oc), .ocn(ocn), .status_flag(status_flag), .irq(irq), .dma_req(dma_req)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int m_mode[NCH], m_main[NCH], m_comp[NCH];
    int p_mode[NCH], p_main[NCH], p_comp[NCH];
    bit m_flag, m_ie, m_de, m_dma, m_prev;
    bit sw_e, tr_e, any_e;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_mode[i] = 0; m_main[i] = 0; m_comp[i] = 0;
                p_mode[i] = 0; p_main[i] = 0; p_comp[i] = 0;
            end
            m_flag = 0; m_ie = 0; m_de = 0; m_dma = 0; m_prev = 1;
        end else begin
            sw_e  = wr_en && (wr_addr == 0) && wr_data[0];
            tr_e  = trg_in && !m_prev;
            any_e = sw_e || tr_e;
            m_dma = any_e && m_de;
            if (any_e) m_flag = 1;
            else if (wr_en && (wr_addr == 1) && !wr_data[0]) m_flag = 0;
            if (any_e)
                for (int i = 0; i < NCH; i++) begin
                    m_mode[i] = p_mode[i]; m_main[i] = p_main[i]; m_comp[i] = p_comp[i];
                end
            if (wr_en && (wr_addr == 2)) begin
                m_ie = wr_data[0]; m_de = wr_data[1];
            end
            if (wr_en && (int'(wr_addr) >= 3) && (int'(wr_addr) < 3 + NCH)) begin
                p_mode[int'(wr_addr) - 3] = int'(wr_data[3:0]);
                p_main[int'(wr_addr) - 3] = int'(wr_data[4]);
                p_comp[int'(wr_addr) - 3] = int'(wr_data[5]);
            end
            m_prev = trg_in;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                int r;
                r = (m_mode[i] == 4) ? 0 : (m_mode[i] == 5) ? 1 : int'(pwm_ref[i]);
                chk("R7", "model oc", int'(oc[i]), m_main[i] != 0 ? r : 0);
                chk("R7", "model ocn", int'(ocn[i]), m_comp[i] != 0 ? 1 - r : 0);
            end
            chk("R8", "model flag", int'(status_flag), int'(m_flag));
            chk("R9", "model irq", int'(irq), int'(m_flag && m_ie));
            chk("R10", "model dma", int'(dma_req), int'(m_dma));
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = 6'(d);
        tick();
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        chk("R1", "reset oc", int'(oc), 0);
        chk("R1", "reset ocn", int'(ocn), 0);
        chk("R1", "reset flag/irq/dma", int'({status_flag, irq, dma_req}), 0);
        rst_n = 1'b1;
        pwm_ref = 3'b101;
        tick();

        wr(3, 6'h35);
        chk("R2", "oc before event", int'(oc), 0);
        wr(0, 1);
        chk("R3", "oc after sw event", int'(oc), 3'b001);
        chk("R6", "ocn forced high ref", int'(ocn), 0);
        chk("R8", "flag set by event", int'(status_flag), 1);
        wr(1, 0);
        chk("R8", "flag cleared", int'(status_flag), 0);

        wr(3, 6'h34); wr(4, 6'h15); wr(5, 6'h20);
        chk("R2", "oc unchanged by preload", int'(oc), 3'b001);
        trg_in = 1'b1;
        tick();
        chk("R4", "oc after trigger edge", int'(oc), 3'b010);
        chk("R5", "ocn with forced low ch0", int'(ocn), 3'b001);
        pwm_ref[2] = 1'b0;
        #1;
        chk("R6", "ch2 passes reference", int'(ocn), 3'b101);
        wr(3, 6'h35);
        repeat (2) tick();
        chk("R4", "held trigger no event", int'(oc[0]), 0);
        trg_in = 1'b0;
        tick();

        wr(2, 0);
        chk("R9", "irq masked", int'(irq), 0);
        wr(2, 1);
        chk("R9", "irq enabled", int'(irq), 1);
        wr(1, 1);
        chk("R8", "write 1 no clear", int'(status_flag), 1);
        wr(1, 0);
        chk("R8", "clear again", int'(status_flag), 0);
        chk("R9", "irq follows flag", int'(irq), 0);
        trg_in = 1'b1;
        wr(1, 0);
        chk("R8", "event beats clear", int'(status_flag), 1);
        trg_in = 1'b0;
        tick();

        wr(2, 2);
        wr(0, 1);
        chk("R10", "dma pulse", int'(dma_req), 1);
        tick();
        chk("R10", "dma one cycle", int'(dma_req), 0);
        trg_in = 1'b1;
        wr(0, 1);
        chk("R10", "joint event dma", int'(dma_req), 1);
        tick();
        chk("R10", "joint event single pulse", int'(dma_req), 0);
        trg_in = 1'b0;
        tick();

        trg_in = 1'b1;
        wr(4, 6'h25);
        chk("R11", "old preload taken", int'(oc[1]), 1);
        trg_in = 1'b0;
        wr(0, 1);
        chk("R11", "new preload on next event", int'(oc[1]), 0);
        chk("R11", "new preload ocn", int'(ocn[1]), 0);
        repeat (3) tick();

        finish_run();
    end

endmodule